// File: doc/BRIEF.md
# Nibble-Register Serial Link Master

This block performs single register accesses to an external timekeeping chip whose registers are each four bits wide. The link has three wires. A serial clock idles high. A bidirectional data line is driven through a separate output-enable. A chip-enable line is handled by logic above this block.

A host raises a request carrying a 4-bit register address, a write flag and, for writes, a 4-bit value. The block first shifts out a tagged command byte. For a write it then shifts out a data byte. For a read it clocks in a reply byte and keeps that byte's low nibble.

A one-cycle done pulse marks the end of each access. Every half-period of the serial clock is a fixed number of system-clock cycles, set by a parameter. The default of 35 cycles at 50 MHz gives the 700 ns minimum that the chip requires.

Top module: `nibreg_serial_master`

## Requirements
- R1: After reset, and whenever no access is in progress, `sclk` is 1, `sdio_oe` is 0 and `busy` is 0; `done` and `rdata` reset to 0.
- R2: A read sends the command byte `{4'b0000, addr} | 8'h60`: bit 6 is the read tag and bit 5 the address tag. Bits go out most-significant first, one per serial clock period. Eight reply bits are then clocked in, also MSB first.
- R3: A write sends the command byte `{4'b0000, addr} | 8'h20`, followed by the data byte `{4'b0000, wdata} | 8'h10` (bit 4 is the data tag), both MSB first.
- R4: Each serial bit holds `sclk` high for HALF_CYC cycles and then low for HALF_CYC cycles. An access therefore keeps `sclk` low for exactly 16*HALF_CYC cycles.
- R5: On a transmitted byte, `sdio_oe` rises one cycle after the first bit is placed on `sdio_o`. It stays high through every rising edge of that byte and falls right after the eighth rising edge. It stays low for every bit of a received byte.
- R6: A received bit is sampled on `sdio_i` at the end of its high half, just before `sclk` falls. Only the low nibble of the reply byte reaches `rdata`, so its upper nibble has no effect. A write leaves `rdata` unchanged.
- R7: `done` is high for exactly one cycle. It is first seen 32*HALF_CYC+7 rising clock edges after the edge that accepts the request, counting the accepting edge as the first.
- R8: A request raised while `busy` is 1 is ignored. It does not change the bytes of the running access, and it does not start another access afterwards.
- R9: `sdio_o` changes only while `sclk` is high. It never changes during a low half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled only while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 4 | Low nibble of the last reply byte |
| sclk | output | 1 | Serial clock, idles high |
| sdio_o | output | 1 | Serial data out |
| sdio_oe | output | 1 | Data-line output enable |
| sdio_i | input | 1 | Serial data in |

## Verification
Every result has a fixed due time counted from the accepting edge:
- Bit k of an access leaves on the serial rising edge 2*HALF_CYC*(k+1) cycles after the engine starts.
- `done` appears 32*HALF_CYC+7 edges after acceptance.

The bench counts clock edges from the request onward and compares that count against the formula. It does not wait on a flag. A slave model samples `sdio_o` and `sdio_oe` on each `sclk` rise, one cycle before the data can move, and feeds reply bits that change only on those rises. All bytes are therefore compared after the access has ended. The bench sweeps every address for reads and for writes, and every write value, using reply bytes with non-zero upper nibbles.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] TAG_READ = 8'h40;
  localparam logic [BYTE_W-1:0] TAG_ADDR = 8'h20;
  localparam logic [BYTE_W-1:0] TAG_DATA = 8'h10;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_HIGH,
    ENG_LOW,
    ENG_END
  } eng_state_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CMD,
    SEQ_DATA
  } seq_state_t;
endpackage

// File: rtl/nrs_halftimer.sv
module nrs_halftimer #(
  parameter int HALF_CYC = 35
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic at_first,
  output logic at_second,
  output logic at_last
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST_V = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt == LAST_V) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_first  = (cnt == '0);
  assign at_second = (cnt == CW'(1));
  assign at_last   = (cnt == LAST_V);
endmodule

// File: rtl/nrs_byte_engine.sv
module nrs_byte_engine
  import nrs_pkg::*;
#(
  parameter int HALF_CYC = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rx_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_i,
  output logic              sclk,
  output logic              sda_o,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done
);
  localparam int IW = $clog2(BYTE_W);
  localparam logic [IW-1:0] LAST_BIT = IW'(BYTE_W - 1);

  eng_state_t        st;
  logic [BYTE_W-1:0] shreg;
  logic [IW-1:0]     idx;
  logic              rx_q;
  logic              t_first, t_second, t_last;

  nrs_halftimer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clr       ((st == ENG_IDLE) || (st == ENG_END)),
    .at_first  (t_first),
    .at_second (t_second),
    .at_last   (t_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ENG_IDLE;
      sclk      <= 1'b1;
      sda_o     <= 1'b0;
      sda_oe    <= 1'b0;
      shreg     <= '0;
      idx       <= '0;
      rx_q      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      case (st)
        ENG_IDLE: begin
          if (start) begin
            st    <= ENG_HIGH;
            idx   <= '0;
            shreg <= tx_byte;
            rx_q  <= rx_mode;
          end
        end
        ENG_HIGH: begin
          if (t_first && !rx_q) sda_o <= shreg[BYTE_W-1];
          if (t_second && !rx_q && idx == '0) sda_oe <= 1'b1;
          if (t_last) begin
            sclk  <= 1'b0;
            st    <= ENG_LOW;
            shreg <= {shreg[BYTE_W-2:0], rx_q ? sda_i : 1'b0};
          end
        end
        ENG_LOW: begin
          if (t_last) begin
            sclk <= 1'b1;
            if (idx == LAST_BIT) begin
              st <= ENG_END;
            end else begin
              idx <= idx + 1'b1;
              st  <= ENG_HIGH;
            end
          end
        end
        default: begin
          sda_oe    <= 1'b0;
          byte_done <= 1'b1;
          st        <= ENG_IDLE;
        end
      endcase
    end
  end

  assign rx_byte = shreg;
endmodule

// File: rtl/nibreg_serial_master.sv
module nibreg_serial_master
  import nrs_pkg::*;
#(
  parameter int HALF_CYC = 35
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic [NIB_W-1:0] req_addr,
  input  logic [NIB_W-1:0] req_wdata,
  output logic             busy,
  output logic             done,
  output logic [NIB_W-1:0] rdata,
  output logic             sclk,
  output logic             sdio_o,
  output logic             sdio_oe,
  input  logic             sdio_i
);
  localparam int PAD_W = BYTE_W - NIB_W;

  seq_state_t        st;
  logic              wr_q;
  logic [NIB_W-1:0]  wdata_q;
  logic              eng_start;
  logic              eng_rx;
  logic [BYTE_W-1:0] eng_byte;
  logic [BYTE_W-1:0] eng_rx_byte;
  logic              eng_done;

  nrs_byte_engine #(.HALF_CYC(HALF_CYC)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (eng_start),
    .rx_mode   (eng_rx),
    .tx_byte   (eng_byte),
    .sda_i     (sdio_i),
    .sclk      (sclk),
    .sda_o     (sdio_o),
    .sda_oe    (sdio_oe),
    .rx_byte   (eng_rx_byte),
    .byte_done (eng_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SEQ_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      rdata     <= '0;
      wr_q      <= 1'b0;
      wdata_q   <= '0;
      eng_start <= 1'b0;
      eng_rx    <= 1'b0;
      eng_byte  <= '0;
    end else begin
      eng_start <= 1'b0;
      done      <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (req) begin
            busy      <= 1'b1;
            wr_q      <= req_wr;
            wdata_q   <= req_wdata;
            eng_byte  <= {{PAD_W{1'b0}}, req_addr} | TAG_ADDR | (req_wr ? '0 : TAG_READ);
            eng_rx    <= 1'b0;
            eng_start <= 1'b1;
            st        <= SEQ_CMD;
          end
        end
        SEQ_CMD: begin
          if (eng_done) begin
            eng_start <= 1'b1;
            eng_rx    <= !wr_q;
            eng_byte  <= {{PAD_W{1'b0}}, wdata_q} | TAG_DATA;
            st        <= SEQ_DATA;
          end
        end
        default: begin
          if (eng_done) begin
            done <= 1'b1;
            busy <= 1'b0;
            if (!wr_q) rdata <= eng_rx_byte[NIB_W-1:0];
            st <= SEQ_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nrs_master_chk.sv
module nrs_master_chk #(
  parameter int HALF_CYC = 35
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic sdio_o,
  input logic sdio_oe
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || sclk) low_run <= '0;
    else             low_run <= low_run + 1'b1;
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk && !sdio_oe)); // R1
  AST_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> (low_run == 16'(HALF_CYC))); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sclk && $past(!sclk)) |-> $stable(sdio_o)); // R9
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy)); // R7
  AST_OE_OFF_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !sdio_oe); // R5
endmodule

bind nibreg_serial_master nrs_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .sclk    (sclk),
  .sdio_o  (sdio_o),
  .sdio_oe (sdio_oe)
);

// File: tb/nibreg_serial_master_bench.sv
`timescale 1ns/1ps
module nibreg_serial_master_bench;
  localparam int H = 35;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       req_wr = 1'b0;
  logic [3:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic       busy, done, sclk, sdio_o, sdio_oe, sdio_i;
  logic [3:0] rdata;

  always #10 clk = ~clk;

  nibreg_serial_master #(.HALF_CYC(H)) u_nibreg_serial_master (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .sclk(sclk), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
  );

  int          tests = 0, fails = 0;
  int          bitcnt = 0, base = 0, low_chg = 0;
  logic [15:0] cap = '0, oeh = '0;
  logic [7:0]  reply = '0;

  // slave model: capture on each serial rising edge
  always @(posedge sclk) begin
    cap    <= {cap[14:0], sdio_o};
    oeh    <= {oeh[14:0], sdio_oe};
    bitcnt <= bitcnt + 1;
  end

  always_comb begin
    int k;
    k = bitcnt - base;
    sdio_i = (k >= 8 && k < 16) ? reply[15-k] : 1'b0;
  end

  always @(sdio_o) if (!rst && sclk === 1'b0) low_chg++;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [3:0] a, input logic [3:0] d,
                        input logic [7:0] rep, input bit interfere);
    int n, lowc, hi_ok;
    logic [3:0] prev_rd;
    logic [7:0] exp_cmd;
    prev_rd = rdata;
    reply   = rep;
    base    = bitcnt;
    exp_cmd = {4'b0, a} | 8'h20 | (wr ? 8'h00 : 8'h40);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    n = 0; lowc = 0;
    do begin
      @(posedge clk); @(negedge clk);
      req = 1'b0;
      n++;
      if (!sclk) lowc++;
      if (interfere && (n == 200 || n == 900)) begin
        req = 1'b1; req_addr = ~a; req_wr = ~wr; req_wdata = ~d;
      end
    end while (!done && n < 5000);
    chk(n == 32*H + 7, "R7 latency", n, 32*H + 7);
    chk(lowc == 16*H, "R4 low cycles", lowc, 16*H);
    chk(bitcnt - base == 16, "R8 bit count", bitcnt - base, 16);
    chk(!sdio_oe, "R5 oe low at done", sdio_oe, 0);
    if (wr) begin
      chk(cap[15:8] == exp_cmd, "R3 write command", cap[15:8], exp_cmd);
      chk(cap[7:0] == ({4'b0, d} | 8'h10), "R3 data byte", cap[7:0], {4'b0, d} | 8'h10);
      chk(oeh == 16'hFFFF, "R5 oe write", oeh, 16'hFFFF);
      chk(rdata == prev_rd, "R6 write keeps rdata", rdata, prev_rd);
    end else begin
      chk(cap[15:8] == exp_cmd, "R2 read command", cap[15:8], exp_cmd);
      chk(oeh == 16'hFF00, "R5 oe read", oeh, 16'hFF00);
      chk(rdata == rep[3:0], "R6 read nibble", rdata, rep[3:0]);
    end
    @(negedge clk);
    chk(!done && !busy, "R7 done single", {done, busy}, 0);
    if (interfere) begin
      hi_ok = 1;
      repeat (3*H) begin
        @(negedge clk);
        if (!sclk || busy) hi_ok = 0;
      end
      chk(hi_ok == 1, "R8 no second access", hi_ok, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(sclk && !sdio_oe && !busy && !done && rdata == 0, "R1 reset state",
        {sclk, sdio_oe, busy, done, rdata}, 8'h80);
    for (int a = 0; a < 16; a++)
      access(1'b0, 4'(a), 4'h0, {4'(a) ^ 4'hA, 4'(a*7 + 3)}, 1'b0);
    for (int a = 0; a < 16; a++) begin
      access(1'b1, 4'(a), ~4'(a), 8'h00, 1'b0);
      access(1'b1, 4'(a), 4'(a), 8'h00, 1'b0);
    end
    for (int d = 0; d < 16; d++)
      access(1'b1, 4'h7, 4'(d), 8'h00, 1'b0);
    access(1'b0, 4'h5, 4'h0, 8'hF6, 1'b1);
    access(1'b1, 4'h9, 4'hC, 8'h00, 1'b1);
    chk(low_chg == 0, "R9 data moves only with sclk high", low_chg, 0);
    chk(sclk && !sdio_oe, "R1 idle lines", {sclk, sdio_oe}, 2'b10);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule